// File: doc/BRIEF.md
# Edge-Selectable 16-bit GPIO Port

The block is a sixteen-pin general-purpose I/O port behind a 16-bit register interface. Every pin is an input or an output, chosen by a direction register. Output pins drive the value held in a data-out register. Input pins pass through a two-flop synchronizer and can be read back through a pin-control gate. Each input pin can also flag an event on one edge, rising or falling, chosen per pin.

Detected edges on unmasked input pins set bits in a status register. A single interrupt line is the OR of the pending status bits that are not masked. Software clears status bits by writing ones to them, which drops the interrupt line once nothing unmasked remains pending. Only 16-bit accesses are accepted. An access of any other width is ignored.

Top module: `gpio16_port`

## Requirements
- R1: After reset, every pin is an input (pad_oe is 0x0000), pad_out is 0x0000 and irq is low. Register reads at that point return: direction (0x08) 0xFFFF, mask (0x10) 0xFFFF, status (0x14) 0x0000, pin control (0x18) 0xFFFF, data out (0x04) 0x0000 and edge select (0x0C) 0x0000.
- R2: A direction bit of 1 makes the pin an input and a bit of 0 makes it an output. After a legal write to offset 0x08, pad_oe equals the inverse of the written value from the next cycle on.
- R3: A legal write to data out (0x04) updates only the bits of pins that are outputs at that moment. Input-pin bits keep their stored value. Reading 0x04 returns the stored value.
- R4: pad_out always carries the stored data-out value. A pin that becomes an output through a direction write therefore drives its stored data-out bit in the next cycle.
- R5: Reading data in (0x00) returns the synchronized pins ANDed with pin control (0x18). A pin change is visible two clock edges after it is applied. Writes to 0x00 have no effect.
- R6: Edge select (0x0C) bit 1 makes the pin detect 0-to-1 changes, and bit 0 makes it detect 1-to-0 changes. A detected edge on an unmasked input pin sets its status bit (0x14) three clock edges after the pin changes.
- R7: A mask bit (0x10) of 1 blocks its pin. Edges on masked pins or on output pins never set status.
- R8: irq is high exactly when some status bit is set whose mask bit is 0. Masking a pending pin drops irq without clearing its status bit, and unmasking it raises irq again.
- R9: A legal write to status clears the bits written as 1. An edge detected on a bit in the same cycle as that bit's clear leaves the bit set.
- R10: An access is legal only when acc_size is 2'b01 (16 bits). An illegal write changes nothing, and an illegal read returns 0x0000.
- R11: Reads of an unmapped offset return 0x0000. Writes to an unmapped offset change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| acc_size | input | 2 | Access width code; 2'b01 = 16 bits |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| pad_in | input | 16 | Pin input levels |
| pad_out | output | 16 | Pin output values |
| pad_oe | output | 16 | Pin output enables, 1 = driving |
| irq | output | 1 | Shared interrupt line |

## Verification
An edge can be detected on a pin in the same cycle as software clears that pin's status bit, and the design must keep the new event. The bench pulses a pending rising-edge pin and times a write of 1 to its status bit so that the write lands on the edge where the new edge is recorded. The following status read must still show the bit set, and irq must stay high. A second collision, where a data-out write meets input-configured pins, is judged by reading back data out and comparing it with the value merged from the direction register.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;
  localparam logic [7:0] OFF_DIN  = 8'h00;
  localparam logic [7:0] OFF_DOUT = 8'h04;
  localparam logic [7:0] OFF_DIR  = 8'h08;
  localparam logic [7:0] OFF_EDGE = 8'h0C;
  localparam logic [7:0] OFF_MASK = 8'h10;
  localparam logic [7:0] OFF_STAT = 8'h14;
  localparam logic [7:0] OFF_PCTL = 8'h18;
  localparam logic [1:0] SIZE_HALF = 2'b01;
endpackage

// File: rtl/gpio16_sync.sv
module gpio16_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio16_edge.sv
module gpio16_edge #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] rise_sel,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      if (rise_sel[i]) hit[i] = cur[i] & ~prev_q[i];
      else             hit[i] = ~cur[i] & prev_q[i];
    end
  end
endmodule

// File: rtl/gpio16_regs.sv
module gpio16_regs
  import gpio16_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    acc_size,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  din_sync,
  input  logic [W-1:0]  hit,
  output logic [W-1:0]  rdata,
  output logic [W-1:0]  dout_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  edge_q,
  output logic [W-1:0]  mask_q,
  output logic [W-1:0]  stat_q,
  output logic [W-1:0]  pctl_q,
  output logic          irq
);
  localparam logic [AW-1:0] A_DIN  = AW'(OFF_DIN);
  localparam logic [AW-1:0] A_DOUT = AW'(OFF_DOUT);
  localparam logic [AW-1:0] A_DIR  = AW'(OFF_DIR);
  localparam logic [AW-1:0] A_EDGE = AW'(OFF_EDGE);
  localparam logic [AW-1:0] A_MASK = AW'(OFF_MASK);
  localparam logic [AW-1:0] A_STAT = AW'(OFF_STAT);
  localparam logic [AW-1:0] A_PCTL = AW'(OFF_PCTL);

  logic         legal, wr_ok;
  logic         dout_en, dir_en, edge_en, mask_en, pctl_en;
  logic [W-1:0] dout_d, stat_d;

  assign legal = (acc_size == SIZE_HALF);
  assign wr_ok = wr_en & legal;

  // next state
  always_comb begin
    dout_en = wr_ok && (addr == A_DOUT);
    dir_en  = wr_ok && (addr == A_DIR);
    edge_en = wr_ok && (addr == A_EDGE);
    mask_en = wr_ok && (addr == A_MASK);
    pctl_en = wr_ok && (addr == A_PCTL);
    // only pins that are outputs take the new value
    dout_d  = (dout_q & dir_q) | (wdata & ~dir_q);
    stat_d  = stat_q;
    if (wr_ok && (addr == A_STAT)) stat_d = stat_q & ~wdata;
    // a fresh event is applied after the clear, so it wins
    stat_d  = stat_d | (hit & dir_q & ~mask_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '1;
      edge_q <= '0;
      mask_q <= '1;
      stat_q <= '0;
      pctl_q <= '1;
    end else begin
      if (dout_en) dout_q <= dout_d;
      if (dir_en)  dir_q  <= wdata;
      if (edge_en) edge_q <= wdata;
      if (mask_en) mask_q <= wdata;
      if (pctl_en) pctl_q <= wdata;
      stat_q <= stat_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (rd_en && legal) begin
      unique case (addr)
        A_DIN:   rdata = din_sync & pctl_q;
        A_DOUT:  rdata = dout_q;
        A_DIR:   rdata = dir_q;
        A_EDGE:  rdata = edge_q;
        A_MASK:  rdata = mask_q;
        A_STAT:  rdata = stat_q;
        A_PCTL:  rdata = pctl_q;
        default: rdata = '0;
      endcase
    end
  end

  assign irq = |(stat_q & ~mask_q);
endmodule

// File: rtl/gpio16_port.sv
module gpio16_port #(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    acc_size,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic          irq
);
  logic [W-1:0] din_sync, hit_v;
  logic [W-1:0] dout_q, dir_q, edge_q, mask_q, stat_q, pctl_q;

  gpio16_sync #(.W(W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(din_sync)
  );

  gpio16_edge #(.W(W)) u_edge (
    .clk(clk), .rst_n(rst_n), .cur(din_sync), .rise_sel(edge_q), .hit(hit_v)
  );

  gpio16_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .acc_size(acc_size), .wdata(wdata), .din_sync(din_sync), .hit(hit_v),
    .rdata(rdata), .dout_q(dout_q), .dir_q(dir_q), .edge_q(edge_q),
    .mask_q(mask_q), .stat_q(stat_q), .pctl_q(pctl_q), .irq(irq)
  );

  assign pad_out = dout_q;
  assign pad_oe  = ~dir_q;
endmodule

// File: rtl/gpio16_chk.sv
module gpio16_chk
  import gpio16_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [1:0]    acc_size,
  input logic [W-1:0]  wdata,
  input logic [W-1:0]  rdata,
  input logic [W-1:0]  pad_out,
  input logic [W-1:0]  pad_oe,
  input logic          irq,
  input logic [W-1:0]  hit_v,
  input logic [W-1:0]  stat_q,
  input logic [W-1:0]  mask_q,
  input logic [W-1:0]  pctl_q
);
  logic legal;
  assign legal = (acc_size == SIZE_HALF);

  p_oe_from_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && legal && addr == AW'(OFF_DIR)) |=> (pad_oe == ~$past(wdata)));

  p_dout_keeps_inputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && legal && addr == AW'(OFF_DOUT)) |=>
      (((pad_out ^ $past(pad_out)) & ~$past(pad_oe)) == '0));

  p_din_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && legal && addr == AW'(OFF_DIN)) |-> ((rdata & ~pctl_q) == '0));

  p_masked_no_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat_q & ~$past(stat_q) & $past(mask_q)) == '0));

  p_clear_drops_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && legal && addr == AW'(OFF_STAT) && wdata == '1 && hit_v == '0) |=> !irq);

  p_bad_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !legal) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio16_port gpio16_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .acc_size(acc_size), .wdata(wdata), .rdata(rdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .irq(irq), .hit_v(hit_v), .stat_q(stat_q),
  .mask_q(mask_q), .pctl_q(pctl_q)
);

// File: tb/tb_gpio16_port.sv
module tb_gpio16_port;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;
  // {write, addr, data, expected read}
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 8'h08, 16'h0000, 16'hFFFF},
    {1'b0, 8'h10, 16'h0000, 16'hFFFF},
    {1'b0, 8'h14, 16'h0000, 16'h0000},
    {1'b0, 8'h18, 16'h0000, 16'hFFFF},
    {1'b0, 8'h04, 16'h0000, 16'h0000},
    {1'b0, 8'h0C, 16'h0000, 16'h0000},
    {1'b1, 8'h08, 16'h00FF, 16'h0000},
    {1'b1, 8'h04, 16'hABCD, 16'h0000},
    {1'b0, 8'h04, 16'h0000, 16'hAB00},
    {1'b1, 8'h08, 16'h0000, 16'h0000},
    {1'b1, 8'h04, 16'h1234, 16'h0000},
    {1'b0, 8'h04, 16'h0000, 16'h1234},
    {1'b1, 8'h0C, 16'h5A5A, 16'h0000},
    {1'b0, 8'h0C, 16'h0000, 16'h5A5A},
    {1'b1, 8'h1C, 16'hBEEF, 16'h0000},
    {1'b0, 8'h1C, 16'h0000, 16'h0000},
    {1'b1, 8'h08, 16'hFFFF, 16'h0000},
    {1'b0, 8'h08, 16'h0000, 16'hFFFF}
  };

  logic        clk, rst_n, wr_en, rd_en, irq;
  logic [7:0]  addr;
  logic [1:0]  acc_size;
  logic [15:0] wdata, rdata, pad_in, pad_out, pad_oe;
  int checks = 0;
  int errors = 0;

  gpio16_port dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .acc_size(acc_size), .wdata(wdata), .rdata(rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] sz = 2'b01);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; acc_size = sz;
    @(negedge clk);
    wr_en = 1'b0; acc_size = 2'b01;
  endtask

  task automatic rd(input logic [7:0] a, input string tag, input logic [15:0] exp,
                    input logic [1:0] sz = 2'b01);
    @(negedge clk);
    rd_en = 1'b1; addr = a; acc_size = sz;
    #1;
    check(tag, rdata, exp);
    rd_en = 1'b0; acc_size = 2'b01;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0;
    acc_size = 2'b01; wdata = '0; pad_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R1 pad_oe", pad_oe, 16'h0000);
    check("R1 pad_out", pad_out, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      string tag;
      if (i < 6)       tag = "R1 table";
      else if (i < 12) tag = "R3 table";
      else if (i < 14) tag = "R6 table";
      else if (i < 16) tag = "R11 table";
      else             tag = "R2 table";
      if (VEC[i][40]) wr(VEC[i][39:32], VEC[i][31:16]);
      else            rd(VEC[i][39:32], tag, VEC[i][15:0]);
    end
    check("R2 pad_oe all inputs", pad_oe, 16'h0000);
    wr(8'h0C, 16'h0000);

    // R4: pins becoming outputs drive stored data out (0x1234)
    wr(8'h08, 16'hFFF0);
    #1;
    check("R2 pad_oe", pad_oe, 16'h000F);
    check("R4 driven", pad_out & pad_oe, 16'h0004);
    wr(8'h08, 16'hFFFF);

    // R5: gated data-in read, write to 0x00 ignored
    @(negedge clk) pad_in = 16'h00F0;
    wr(8'h18, 16'h00C0);
    rd(8'h00, "R5 gated", 16'h00C0);
    wr(8'h00, 16'hFFFF);
    rd(8'h00, "R5 write ignored", 16'h00C0);
    rd(8'h14, "R7 masked edges", 16'h0000);
    wr(8'h18, 16'hFFFF);
    @(negedge clk) pad_in = 16'h0000;
    settle();

    // R6: bit0 rising, bit1 falling
    wr(8'h0C, 16'h0001);
    wr(8'h10, 16'hFFFC);
    wr(8'h14, 16'hFFFF);
    @(negedge clk) pad_in = 16'h0003;
    settle();
    rd(8'h14, "R6 rising", 16'h0001);
    check("R8 irq on", {15'd0, irq}, 16'h0001);
    @(negedge clk) pad_in = 16'h0000;
    settle();
    rd(8'h14, "R6 falling", 16'h0003);

    // R9: write-one clear
    wr(8'h14, 16'h0001);
    rd(8'h14, "R9 partial clear", 16'h0002);
    check("R9 irq held", {15'd0, irq}, 16'h0001);
    wr(8'h14, 16'h0002);
    rd(8'h14, "R9 full clear", 16'h0000);
    check("R9 irq low", {15'd0, irq}, 16'h0000);

    // R8: masking a pending pin
    @(negedge clk) pad_in = 16'h0001;
    settle();
    wr(8'h10, 16'hFFFD);
    #1;
    check("R8 masked irq", {15'd0, irq}, 16'h0000);
    rd(8'h14, "R8 status kept", 16'h0001);
    wr(8'h10, 16'hFFFC);
    #1;
    check("R8 unmasked irq", {15'd0, irq}, 16'h0001);
    wr(8'h14, 16'hFFFF);

    // R7: edge on an output pin
    wr(8'h08, 16'hFFFB);
    wr(8'h10, 16'hFFF8);
    wr(8'h0C, 16'h0005);
    @(negedge clk) pad_in = 16'h0005;
    settle();
    rd(8'h14, "R7 output pin", 16'h0000);
    check("R7 irq", {15'd0, irq}, 16'h0000);
    wr(8'h08, 16'hFFFF);
    wr(8'h10, 16'hFFFC);

    // R9: clear and new edge in the same cycle
    @(negedge clk) pad_in = 16'h0004;
    settle();
    @(negedge clk) pad_in = 16'h0005;
    settle();
    @(negedge clk) pad_in = 16'h0004;
    settle();
    rd(8'h14, "R9 pending", 16'h0001);
    @(negedge clk) pad_in = 16'h0005;
    @(negedge clk);
    wr(8'h14, 16'h0001);
    rd(8'h14, "R9 set wins", 16'h0001);
    check("R9 irq stays", {15'd0, irq}, 16'h0001);

    // R10: illegal widths
    wr(8'h08, 16'h0000, 2'b10);
    #1;
    check("R10 write ignored", pad_oe, 16'h0000);
    rd(8'h08, "R10 read zero", 16'h0000, 2'b00);
    rd(8'h08, "R10 legal read", 16'hFFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule